// File: doc/BRIEF.md
# Vector Mask Register Unit

This block keeps the per-element mask of a vector processor: one bit for each of the 64 vector elements, where a set bit allows that element's result to be written. Execution units read the live mask from the `mask_q` output to predicate their element writes. The same output also serves as the read path when the mask is copied into a scalar register.

The mask changes in four ways. An equality compare of two vector operands updates it one element per cycle: the operands arrive with an element index, and the indexed bit becomes 1 on a match and 0 otherwise. A clear request sets every bit to 1. A scalar write loads all 64 bits at once. After reset the mask is all ones, so operation is unmasked by default.

A population-count request returns the number of set bits as a 7-bit scalar result one cycle later. Compares only affect elements whose index is below the current vector length. This lets a short vector leave the upper part of the mask untouched.

Top module: `vmask_unit`

## Requirements
- R1: After reset, `mask_q` is all ones, `pop_valid` is 0 and `pop_count` is 0.
- R2: A compare with `cmp_valid` high, `cmp_idx` below `vlen` and `cmp_a == cmp_b` sets bit `cmp_idx` of `mask_q` to 1 at the next clock edge.
- R3: A compare with `cmp_valid` high, `cmp_idx` below `vlen` and `cmp_a != cmp_b` clears bit `cmp_idx` of `mask_q` at the next clock edge.
- R4: A compare whose `cmp_idx` is at or above `vlen` leaves `mask_q` unchanged. With `vlen` = 0, no compare has any effect.
- R5: A compare changes no mask bit other than bit `cmp_idx`.
- R6: When `pop_req` is high at a clock edge, `pop_count` takes the number of ones in `mask_q` as it was before that edge. `pop_valid` is high in exactly the following cycle, and `pop_count` holds its value until the next request.
- R7: `clr_req` sets every bit of `mask_q` to 1 at the next edge.
- R8: `scl_wr` loads `scl_wdata` into the mask at the next edge, and `mask_q` then shows that value unchanged.
- R9: Priority in one cycle is: `scl_wr` first, then `clr_req`, then a compare.
- R10: `pop_count` reaches both 64 for a full mask and 0 for an empty mask, and never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlen | input | 7 | Current vector length, 0 to 64 |
| cmp_valid | input | 1 | Compare element present this cycle |
| cmp_idx | input | 6 | Index of the compared element |
| cmp_a | input | 64 | First operand element |
| cmp_b | input | 64 | Second operand element |
| clr_req | input | 1 | Set all mask bits to 1 |
| scl_wr | input | 1 | Load the mask from the scalar value |
| scl_wdata | input | 64 | Scalar value to load |
| pop_req | input | 1 | Request a count of the set mask bits |
| pop_count | output | 7 | Count result |
| pop_valid | output | 1 | Count result is new this cycle |
| mask_q | output | 64 | Current mask, for predication and scalar read-back |

## Verification
Every index from 0 to 63 is compared at full length, using a mix of equal operands and operands that differ in a single bit. Checking the whole mask after each step separates a wrong match result from a write to the wrong bit. The same all-unequal sweep then runs at vector lengths 0, 1, 17 and 63, which shows whether the length boundary is exclusive and whether the upper bits are protected. Colliding requests in one cycle expose the priority order. A count taken in the same cycle as a write shows whether the count samples the mask before or after the update.

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int IW   = $clog2(NELEM),
  localparam int CW   = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    vlen,
  input  logic             cmp_valid,
  input  logic [IW-1:0]    cmp_idx,
  input  logic [EW-1:0]    cmp_a,
  input  logic [EW-1:0]    cmp_b,
  input  logic             clr_req,
  input  logic             scl_wr,
  input  logic [NELEM-1:0] scl_wdata,
  input  logic             pop_req,
  output logic [CW-1:0]    pop_count,
  output logic             pop_valid,
  output logic [NELEM-1:0] mask_q
);

  function automatic logic [CW-1:0] count_ones(input logic [NELEM-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NELEM; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic cmp_hit;
  logic cmp_eq;

  assign cmp_hit = cmp_valid && (CW'(cmp_idx) < vlen);
  assign cmp_eq  = (cmp_a == cmp_b);

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= '1;
    else if (scl_wr)     mask_q <= scl_wdata;
    else if (clr_req)    mask_q <= '1;
    else if (cmp_hit)    mask_q[cmp_idx] <= cmp_eq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_count <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= pop_req;
      if (pop_req) pop_count <= count_ones(mask_q);
    end
  end

  // R8
  scl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_wr |=> mask_q == $past(scl_wdata));

  // R7
  clr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !scl_wr) |=> &mask_q);

  // R4
  out_of_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !scl_wr && !clr_req && (CW'(cmp_idx) >= vlen)) |=> $stable(mask_q));

  // R5
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_wr && !clr_req) |=> $countones(mask_q ^ $past(mask_q)) <= 1);

  // R6
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> pop_valid);

  // R6
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |=> (!pop_valid && $stable(pop_count)));

  // R10
  pop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_count <= CW'(NELEM));

endmodule

// File: tb/vmask_unit_bench.sv
module vmask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    vlen = 7'd64;
  logic          cmp_valid = 1'b0;
  logic [5:0]    cmp_idx = '0;
  logic [63:0]   cmp_a = '0;
  logic [63:0]   cmp_b = '0;
  logic          clr_req = 1'b0;
  logic          scl_wr = 1'b0;
  logic [63:0]   scl_wdata = '0;
  logic          pop_req = 1'b0;
  logic [6:0]    pop_count;
  logic          pop_valid;
  logic [63:0]   mask_q;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [63:0] model;

  vmask_unit u_vmask_unit (
    .clk(clk), .rst_n(rst_n), .vlen(vlen), .cmp_valid(cmp_valid),
    .cmp_idx(cmp_idx), .cmp_a(cmp_a), .cmp_b(cmp_b), .clr_req(clr_req),
    .scl_wr(scl_wr), .scl_wdata(scl_wdata), .pop_req(pop_req),
    .pop_count(pop_count), .pop_valid(pop_valid), .mask_q(mask_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int ones(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 0; clr_req = 0; scl_wr = 0; pop_req = 0;
  endtask

  task automatic do_cmp(input int idx, input bit eq, input string req);
    cmp_valid = 1;
    cmp_idx   = 6'(idx);
    cmp_a     = 64'h0123_4567_89ab_cdef ^ 64'(idx);
    cmp_b     = eq ? cmp_a : (cmp_a ^ (64'd1 << ((idx * 7) % 64)));
    if (idx < int'(vlen)) model[idx] = eq;
    step();
    chk(req, mask_q, model);
  endtask

  task automatic do_load(input logic [63:0] v);
    scl_wr = 1; scl_wdata = v; model = v;
    step();
    chk("R8", mask_q, model);
  endtask

  task automatic do_pop(input string req);
    int exp;
    exp = ones(model);
    pop_req = 1;
    step();
    chk(req, 64'(pop_count), 64'(exp));
    chk("R6", 64'(pop_valid), 64'd1);
    step();
    chk("R6", 64'(pop_valid), 64'd0);
    chk("R6", 64'(pop_count), 64'(exp));
  endtask

  initial begin
    model = '1;
    repeat (3) @(negedge clk);
    chk("R1", mask_q, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1", 64'(pop_valid), 64'd0);
    chk("R1", 64'(pop_count), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", mask_q, 64'hFFFF_FFFF_FFFF_FFFF);

    // R10: full mask counts to 64
    do_pop("R10");

    // R2 R3 R5: full-length sweep over every index
    vlen = 7'd64;
    for (int i = 0; i < N; i++) do_cmp(i, (i % 3) != 0, (i % 3) != 0 ? "R2" : "R3");
    do_pop("R6");
    for (int i = 0; i < N; i++) do_cmp(i, (i % 3) == 0, (i % 3) == 0 ? "R2" : "R3");
    do_pop("R6");

    // R7
    clr_req = 1; model = '1;
    step();
    chk("R7", mask_q, model);

    // R4: length boundary sweep
    for (int k = 0; k < 4; k++) begin
      int vl;
      vl = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 17 : 63;
      do_load('1);
      vlen = 7'(vl);
      for (int i = 0; i < N; i++) do_cmp(i, 1'b0, "R4");
      chk("R4", mask_q, (vl == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : ~((64'd1 << vl) - 64'd1));
    end
    vlen = 7'd64;

    // R10: empty mask counts to 0
    do_load('0);
    do_pop("R10");
    do_load(64'hA5A5_0F0F_3C3C_8001);
    do_pop("R6");

    // R9: scalar write beats clear and compare
    scl_wr = 1; scl_wdata = 64'h0000_FFFF_0000_1234;
    clr_req = 1; cmp_valid = 1; cmp_idx = 6'd0; cmp_a = 1; cmp_b = 2;
    model = scl_wdata;
    step();
    chk("R9", mask_q, model);

    // R9: clear beats compare
    clr_req = 1; cmp_valid = 1; cmp_idx = 6'd5; cmp_a = 1; cmp_b = 2;
    model = '1;
    step();
    chk("R9", mask_q, model);

    // R6: count samples the mask before a same-cycle write
    pop_req = 1; scl_wr = 1; scl_wdata = 64'h0F;
    step();
    chk("R6", 64'(pop_count), 64'd64);
    chk("R8", mask_q, 64'h0F);
    model = 64'h0F;
    do_pop("R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule